// File: doc/BRIEF.md
# Page-Granular Memory Protection Checker

This block sits beside the CPU's path to memory and compares each request, a physical address with a read or write indication, against four software-programmed protection windows. Each window covers an inclusive range of 1 KiB pages. The page number of a request is its address shifted right by ten. Each window carries a two-bit permission that can deny everything, allow reads only, allow writes only, or allow both.

When a request lands in a window whose permission forbids it, the block does three things. It raises that window's pending flag. It records the faulting address with the five lowest bits dropped, provided no earlier fault is still pending. It drives an interrupt line, subject to per-window enables and one global enable. The request itself is never stopped or altered. Software sets up and services the block through 16-bit registers at fixed byte offsets.

Top module: `mprot_checker`

## Requirements
- R1: After reset, every register reads 0 and `irq` is low.
- R2: Window bounds, the permission register and the enable register read back as written. Window n's first page is at offset 4n and its last page at offset 4n+2. Permissions are at 0x10, with window n in bits 2n+1:2n and bits 15:8 reading 0. Enables are at 0x1C, with window n in bit n, the global enable in bit 4, and bits 15:5 reading 0.
- R3: A request falls in window n when first <= (addr >> 10) <= last, and both bounds count as inside.
- R4: Permission codes are 00 = no access, 01 = read only, 10 = write only and 11 = read and write. A request that its window forbids sets status bit n (offset 0x1E) at the next clock edge.
- R5: Requests that hit no window, or that their window allows, leave the status register unchanged.
- R6: When windows overlap, every window that forbids the request sets its own status bit in the same cycle.
- R7: Writing 1 to status bit n clears it, and writing 0 leaves it unchanged. A fault in the same cycle as a clear of the same bit leaves the bit set.
- R8: On a fault while no status bit is pending, offset 0x22 bits 15:5 take address bits 15:5 (bits 4:0 read 0), and offset 0x24 bits 13:0 take address bits 29:16. While any status bit is pending, both registers hold their value.
- R9: A status bit is set whether or not its enable is set. `irq` is high exactly when the global enable is set and some status bit is set together with its enable. Status bit 4 reads the value of `irq`.
- R10: Writes to the fault address registers (0x22, 0x24) have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | A CPU request is present this cycle |
| req_write | input | 1 | 1 = write request, 0 = read request |
| req_addr | input | 30 | Physical byte address of the request |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 8 | Register byte offset (even offsets only) |
| reg_wdata | input | 16 | Register write data |
| reg_rdata | output | 16 | Register read data for reg_addr |
| irq | output | 1 | Protection interrupt |

## Verification
The assertions check several rules on every cycle. They check that a forbidden request always sets its window's flag at the next edge, and that no flag rises without such a request. They check that flags are never cleared except by a status write, and that the captured address stays frozen while anything is pending. They also check that the interrupt never rises without the global enable and a matching enabled flag. Other behaviour shows only in the bench's scenarios: the inclusive bounds at both ends of a window, the decode of each permission code, overlapping windows, the priority of a set over a clear in the same cycle, the exact bit layout of the captured address, and writes being ignored.

// File: rtl/mprot_pkg.sv
package mprot_pkg;

    localparam int REG_AW = 8;
    localparam int REG_DW = 16;

    localparam logic [REG_AW-1:0] OFF_PERM   = 8'h10;
    localparam logic [REG_AW-1:0] OFF_IEN    = 8'h1C;
    localparam logic [REG_AW-1:0] OFF_STAT   = 8'h1E;
    localparam logic [REG_AW-1:0] OFF_FLT_LO = 8'h22;
    localparam logic [REG_AW-1:0] OFF_FLT_HI = 8'h24;

    typedef enum logic [1:0] {
        PERM_NONE = 2'b00,
        PERM_RD   = 2'b01,
        PERM_WR   = 2'b10,
        PERM_RW   = 2'b11
    } perm_e;

    function automatic logic perm_allows(perm_e p, logic is_write);
        logic ok;
        unique case (p)
            PERM_NONE: ok = 1'b0;
            PERM_RD:   ok = !is_write;
            PERM_WR:   ok = is_write;
            default:   ok = 1'b1;
        endcase
        return ok;
    endfunction

endpackage

// File: rtl/mprot_region.sv
module mprot_region #(
    parameter int PN_W    = 20,
    parameter int BOUND_W = 16
) (
    input  logic [PN_W-1:0]    page,
    input  logic [BOUND_W-1:0] first_pg,
    input  logic [BOUND_W-1:0] last_pg,
    input  logic [1:0]         perm,
    input  logic               req_valid,
    input  logic               req_write,
    output logic               fault
);
    import mprot_pkg::*;

    logic in_range;
    logic allowed;

    always_comb begin
        in_range = (page >= PN_W'(first_pg)) && (page <= PN_W'(last_pg));
        allowed  = perm_allows(perm_e'(perm), req_write);
        fault    = req_valid && in_range && !allowed;
    end

endmodule

// File: rtl/mprot_fault_capture.sv
module mprot_fault_capture #(
    parameter int ADDR_W    = 30,
    parameter int DROP_BITS = 5
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load,
    input  logic [ADDR_W-1:0] addr,
    output logic [15:0]       lo_reg,
    output logic [15:0]       hi_reg
);
    localparam int LO_W = 16 - DROP_BITS;
    localparam int HI_W = ADDR_W - 16;

    typedef struct packed {
        logic [LO_W-1:0] lo;
        logic [HI_W-1:0] hi;
    } cap_t;

    cap_t cap_d, cap_q;
    logic unused_low_bits;

    always_comb begin
        cap_d = cap_q;
        if (load) begin
            cap_d.lo = addr[15:DROP_BITS];
            cap_d.hi = addr[ADDR_W-1:16];
        end
        unused_low_bits = ^addr[DROP_BITS-1:0];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cap_q <= '0;
        else        cap_q <= cap_d;
    end

    assign lo_reg = {cap_q.lo, {DROP_BITS{1'b0}}};
    assign hi_reg = 16'(cap_q.hi);

endmodule

// File: rtl/mprot_checker.sv
module mprot_checker #(
    parameter int NREG       = 4,
    parameter int ADDR_W     = 30,
    parameter int PAGE_SHIFT = 10,
    parameter int BOUND_W    = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    input  logic              req_write,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic              reg_we,
    input  logic [7:0]        reg_addr,
    input  logic [15:0]       reg_wdata,
    output logic [15:0]       reg_rdata,
    output logic              irq
);
    import mprot_pkg::*;

    localparam int PN_W    = ADDR_W - PAGE_SHIFT;
    localparam int PERM_W  = 2 * NREG;
    localparam int GLB_BIT = NREG;
    localparam int WA_W    = REG_AW - 1;

    typedef struct packed {
        logic [NREG-1:0][BOUND_W-1:0] first_pg;
        logic [NREG-1:0][BOUND_W-1:0] last_pg;
        logic [PERM_W-1:0]            perm;
        logic [NREG-1:0]              ien;
        logic                         glb;
        logic [NREG-1:0]              status;
    } state_t;

    state_t st_d, st_q;

    logic [PN_W-1:0]  page;
    logic [NREG-1:0]  viol;
    logic [NREG-1:0]  status_q;
    logic [NREG-1:0]  ien_q;
    logic             glb_q;
    logic             stat_wr;
    logic             cap_load;
    logic [15:0]      fault_lo;
    logic [15:0]      fault_hi;
    logic [WA_W-1:0]  wsel;
    logic             aligned;

    assign page     = req_addr[ADDR_W-1:PAGE_SHIFT];
    assign status_q = st_q.status;
    assign ien_q    = st_q.ien;
    assign glb_q    = st_q.glb;
    assign wsel     = reg_addr[REG_AW-1:1];
    assign aligned  = !reg_addr[0];
    assign stat_wr  = reg_we && aligned && (wsel == OFF_STAT[REG_AW-1:1]);

    genvar g;
    generate
        for (g = 0; g < NREG; g++) begin : g_region
            mprot_region #(
                .PN_W    (PN_W),
                .BOUND_W (BOUND_W)
            ) u_region (
                .page      (page),
                .first_pg  (st_q.first_pg[g]),
                .last_pg   (st_q.last_pg[g]),
                .perm      (st_q.perm[2*g+1:2*g]),
                .req_valid (req_valid),
                .req_write (req_write),
                .fault     (viol[g])
            );
        end
    endgenerate

    assign cap_load = (|viol) && (st_q.status == '0);

    mprot_fault_capture #(
        .ADDR_W    (ADDR_W),
        .DROP_BITS (5)
    ) u_capture (
        .clk    (clk),
        .rst_n  (rst_n),
        .load   (cap_load),
        .addr   (req_addr),
        .lo_reg (fault_lo),
        .hi_reg (fault_hi)
    );

    // Next-state computation: register writes, then status set/clear.
    always_comb begin
        logic [NREG-1:0] clr;
        st_d = st_q;
        clr  = '0;
        if (reg_we && aligned) begin
            for (int i = 0; i < NREG; i++) begin
                if (wsel == WA_W'(2 * i))     st_d.first_pg[i] = reg_wdata[BOUND_W-1:0];
                if (wsel == WA_W'(2 * i + 1)) st_d.last_pg[i]  = reg_wdata[BOUND_W-1:0];
            end
            if (wsel == OFF_PERM[REG_AW-1:1]) st_d.perm = reg_wdata[PERM_W-1:0];
            if (wsel == OFF_IEN[REG_AW-1:1]) begin
                st_d.ien = reg_wdata[NREG-1:0];
                st_d.glb = reg_wdata[GLB_BIT];
            end
        end
        if (stat_wr) clr = reg_wdata[NREG-1:0];
        // A fault in the same cycle wins over a clear.
        st_d.status = (st_q.status & ~clr) | viol;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign irq = st_q.glb && |(st_q.status & st_q.ien);

    // Read mux.
    always_comb begin
        reg_rdata = '0;
        if (aligned) begin
            for (int i = 0; i < NREG; i++) begin
                if (wsel == WA_W'(2 * i))     reg_rdata = 16'(st_q.first_pg[i]);
                if (wsel == WA_W'(2 * i + 1)) reg_rdata = 16'(st_q.last_pg[i]);
            end
            if (wsel == OFF_PERM[REG_AW-1:1]) reg_rdata = 16'(st_q.perm);
            if (wsel == OFF_IEN[REG_AW-1:1]) begin
                reg_rdata[NREG-1:0] = st_q.ien;
                reg_rdata[GLB_BIT]  = st_q.glb;
            end
            if (wsel == OFF_STAT[REG_AW-1:1]) begin
                reg_rdata[NREG-1:0] = st_q.status;
                reg_rdata[GLB_BIT]  = irq;
            end
            if (wsel == OFF_FLT_LO[REG_AW-1:1]) reg_rdata = fault_lo;
            if (wsel == OFF_FLT_HI[REG_AW-1:1]) reg_rdata = fault_hi;
        end
    end

endmodule

// File: rtl/mprot_checker_sva.sv
module mprot_checker_sva #(
    parameter int NREG = 4
) (
    input logic            clk,
    input logic            rst_n,
    input logic            irq,
    input logic [NREG-1:0] status_q,
    input logic [NREG-1:0] ien_q,
    input logic            glb_q,
    input logic [NREG-1:0] viol,
    input logic            stat_wr,
    input logic [15:0]     fault_lo,
    input logic [15:0]     fault_hi
);

    // R4: a forbidden request sets its own flag at the next edge
    assert_set_on_fault_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (|viol) |=> ((status_q & $past(viol)) == $past(viol)));

    // R5: no flag rises without a forbidden request the cycle before
    assert_no_spurious_R5: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> ((status_q & ~$past(status_q) & ~$past(viol)) == '0));

    // R7: flags only fall through a status write
    assert_sticky_R7: assert property (@(posedge clk) disable iff (!rst_n)
        !stat_wr |=> ((status_q & $past(status_q)) == $past(status_q)));

    // R8: the first fault address is kept while anything is pending
    assert_first_fault_kept_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (status_q != '0) |=> $stable({fault_hi, fault_lo}));

    // R9: interrupt needs the global enable
    assert_irq_gated_R9: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> glb_q);

    // R9: interrupt needs an enabled pending flag
    assert_irq_source_R9: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> ((status_q & ien_q) != '0));

endmodule

bind mprot_checker mprot_checker_sva #(.NREG(NREG)) u_sva (
    .clk      (clk),
    .rst_n    (rst_n),
    .irq      (irq),
    .status_q (status_q),
    .ien_q    (ien_q),
    .glb_q    (glb_q),
    .viol     (viol),
    .stat_wr  (stat_wr),
    .fault_lo (fault_lo),
    .fault_hi (fault_hi)
);

// File: tb/tb_mprot_checker.sv
`timescale 1ns/1ps
module tb_mprot_checker;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic        req_write = 1'b0;
    logic [29:0] req_addr = '0;
    logic        reg_we = 1'b0;
    logic [7:0]  reg_addr = '0;
    logic [15:0] reg_wdata = '0;
    logic [15:0] reg_rdata;
    logic        irq;
    logic        chk = 1'b0;
    logic        done = 1'b0;

    int total = 0;
    int bad = 0;

    typedef struct {
        logic [15:0] data;
        logic        irqv;
        string       tag;
    } exp_t;

    exp_t sb[$];

    always #2.5 clk = ~clk;

    mprot_checker dut (
        .clk       (clk),
        .rst_n     (rst_n),
        .req_valid (req_valid),
        .req_write (req_write),
        .req_addr  (req_addr),
        .reg_we    (reg_we),
        .reg_addr  (reg_addr),
        .reg_wdata (reg_wdata),
        .reg_rdata (reg_rdata),
        .irq       (irq)
    );

    // Monitor: compare every requested read against the scoreboard.
    always @(negedge clk) begin
        if (chk) begin
            total++;
            if (sb.size() == 0) begin
                bad++;
                $display("FAIL scoreboard empty: act=%h", reg_rdata);
            end else begin
                exp_t e;
                e = sb.pop_front();
                if (reg_rdata !== e.data || irq !== e.irqv) begin
                    bad++;
                    $display("FAIL %s: addr=%h act data=%h irq=%b exp data=%h irq=%b",
                             e.tag, reg_addr, reg_rdata, irq, e.data, e.irqv);
                end
            end
        end
    end

    task automatic quiet();
        reg_we = 1'b0; req_valid = 1'b0; chk = 1'b0;
    endtask

    task automatic idle();
        @(posedge clk); #1; quiet();
    endtask

    task automatic wr(input logic [7:0] a, input logic [15:0] d);
        @(posedge clk); #1; quiet();
        reg_we = 1'b1; reg_addr = a; reg_wdata = d;
    endtask

    task automatic acc(input logic [29:0] a, input logic w);
        @(posedge clk); #1; quiet();
        req_valid = 1'b1; req_addr = a; req_write = w;
    endtask

    task automatic wr_acc(input logic [7:0] ra, input logic [15:0] d,
                          input logic [29:0] a, input logic w);
        @(posedge clk); #1; quiet();
        reg_we = 1'b1; reg_addr = ra; reg_wdata = d;
        req_valid = 1'b1; req_addr = a; req_write = w;
    endtask

    task automatic rd(input logic [7:0] a, input logic [15:0] d,
                      input logic iv, input string tag);
        exp_t e;
        @(posedge clk); #1; quiet();
        reg_addr = a; chk = 1'b1;
        e.data = d; e.irqv = iv; e.tag = tag;
        sb.push_back(e);
    endtask

    initial begin
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;

        // R1: reset values
        rd(8'h00, 16'h0000, 1'b0, "R1 first0");
        rd(8'h0E, 16'h0000, 1'b0, "R1 last3");
        rd(8'h10, 16'h0000, 1'b0, "R1 perm");
        rd(8'h1C, 16'h0000, 1'b0, "R1 ien");
        rd(8'h1E, 16'h0000, 1'b0, "R1 status");
        rd(8'h22, 16'h0000, 1'b0, "R1 fault lo");
        rd(8'h24, 16'h0000, 1'b0, "R1 fault hi");

        // R2: program windows and permissions
        wr(8'h00, 16'h0010); wr(8'h02, 16'h001F);
        wr(8'h04, 16'h0018); wr(8'h06, 16'h0030);
        wr(8'h08, 16'h0100); wr(8'h0A, 16'h0100);
        wr(8'h0C, 16'h0200); wr(8'h0E, 16'h02FF);
        wr(8'h10, 16'hFFC9); // w0 RD, w1 WR, w2 none, w3 RW
        rd(8'h00, 16'h0010, 1'b0, "R2 first0");
        rd(8'h06, 16'h0030, 1'b0, "R2 last1");
        rd(8'h0C, 16'h0200, 1'b0, "R2 first3");
        rd(8'h0E, 16'h02FF, 1'b0, "R2 last3");
        rd(8'h10, 16'h00C9, 1'b0, "R2 perm upper bits zero");

        // R5 / R3: allowed or unmatched requests
        acc(30'h0004800, 1'b0);   // page 0x12, w0 read ok
        acc(30'h0094000, 1'b1);   // page 0x250, w3 write ok
        acc(30'h1400000, 1'b0);   // page 0x5000, no window
        acc(30'h0003C00, 1'b1);   // page 0x0F, just below w0
        acc(30'h0008000, 1'b1);   // page 0x20, past w0, w1 write ok
        rd(8'h1E, 16'h0000, 1'b0, "R5 no fault");

        // R4 / R3 / R9 / R8: write to read-only at first page
        acc(30'h00043F7, 1'b1);
        rd(8'h1E, 16'h0001, 1'b0, "R9 set with enable clear");
        rd(8'h22, 16'h43E0, 1'b0, "R8 fault lo");
        rd(8'h24, 16'h0000, 1'b0, "R8 fault hi");

        // R4 / R8: no-access window while pending
        acc(30'h0040123, 1'b0);
        rd(8'h1E, 16'h0005, 1'b0, "R4 deny window");
        rd(8'h22, 16'h43E0, 1'b0, "R8 first fault kept");

        // R9: enables
        wr(8'h1C, 16'h0004);
        rd(8'h1C, 16'h0004, 1'b0, "R9 no global no irq");
        wr(8'h1C, 16'hFFF4);
        rd(8'h1C, 16'h0014, 1'b1, "R2 ien readback");
        rd(8'h1E, 16'h0015, 1'b1, "R9 status bit4 shows irq");

        // R10: fault registers ignore writes
        wr(8'h22, 16'hFFFF); wr(8'h24, 16'hFFFF);
        rd(8'h22, 16'h43E0, 1'b1, "R10 lo unchanged");
        rd(8'h24, 16'h0000, 1'b1, "R10 hi unchanged");

        // R7: write one to clear
        wr(8'h1E, 16'h0000);
        rd(8'h1E, 16'h0015, 1'b1, "R7 zero write keeps");
        wr(8'h1E, 16'h0004);
        rd(8'h1E, 16'h0001, 1'b0, "R7 clear bit2");
        wr_acc(8'h1E, 16'h0001, 30'h0007C00, 1'b1); // last page of w0
        rd(8'h1E, 16'h0001, 1'b0, "R7 set beats clear R3 last page");
        rd(8'h22, 16'h43E0, 1'b0, "R8 still first fault");
        wr(8'h1E, 16'h0001);
        rd(8'h1E, 16'h0000, 1'b0, "R7 all clear");

        // R8: new capture after clear
        acc(30'h0040123, 1'b0);
        rd(8'h1E, 16'h0014, 1'b1, "R9 irq from w2");
        rd(8'h22, 16'h0120, 1'b1, "R8 new fault lo");
        rd(8'h24, 16'h0004, 1'b1, "R8 new fault hi");
        wr(8'h1E, 16'h0004);
        rd(8'h1E, 16'h0000, 1'b0, "R7 cleared irq drops");

        // R6: overlapping windows at page 0x1C
        wr(8'h10, 16'h00C1); // w1 none
        acc(30'h0007000, 1'b0);
        rd(8'h1E, 16'h0002, 1'b0, "R6 read only w1 faults");
        wr(8'h1E, 16'h000F);
        acc(30'h0007000, 1'b1);
        rd(8'h1E, 16'h0003, 1'b0, "R6 write both fault");
        wr(8'h1E, 16'h000F);

        // R4: write-only window
        wr(8'h10, 16'h00C9);
        acc(30'h0008000, 1'b1);
        rd(8'h1E, 16'h0000, 1'b0, "R4 write-only allows write");
        acc(30'h0008000, 1'b0);
        rd(8'h1E, 16'h0002, 1'b0, "R4 write-only denies read");

        idle();
        @(negedge clk);
        done = 1'b1;
        if (sb.size() != 0) begin
            total++; bad++;
            $display("FAIL scoreboard leftover: act=%0d exp=0", sb.size());
        end
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            total++; bad++;
            $display("FAIL watchdog: act=timeout exp=completion");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

endmodule